// File: doc/BRIEF.md
# Home-Node Coherence Directory

This block sits at the home node of a small shared-memory system with a fixed number of caches. For every memory block it holds one directory entry. The entry records which caches have a copy, through one presence bit per cache, and whether the block is uncached, shared, or held exclusively by a single owner. A simple internal RAM stands in for the backing memory.

Caches send read misses, write misses and releases, each tagged with the requester number and the block index. The controller looks up the entry. It answers from memory when it can. When another cache holds the only valid copy, it fetches that copy from the owner first. On a write miss it sends invalidates only to the caches whose presence bit is set. It counts their acknowledgements and grants exclusive access only when every one has come back. The controller handles one transaction at a time. Its request port is held off with a ready signal until the response has gone out.

Top module: `dir_home_ctrl`

## Requirements
- R1: After reset, every entry is uncached with an all-zero presence vector, memory block i holds 0xA0000000 + i, `req_ready` is 1, and `rsp_valid` and `msg_valid` are 0.
- R2: A read miss (`req_op` = 0) to an uncached or shared block sends no message and returns the memory word with `rsp_excl` = 0. The entry becomes shared, with the requester's bit added to the bits already set.
- R3: A read miss to a block that another cache holds exclusively sends exactly one fetch message (`msg_kind` = 1) to that owner. The data in the owner's acknowledgement is written to memory and returned to the requester. The entry becomes shared, with both the owner's and the requester's bits set.
- R4: A write miss (`req_op` = 1) sends one invalidate (`msg_kind` = 0) per cycle, lowest cache number first, to each cache whose presence bit is set, other than the requester. The response carries `rsp_excl` = 1.
- R5: No message is ever sent to a cache whose presence bit is clear, nor to the requester itself. A write miss to an uncached block, or to a block the requester already owns, sends no message at all.
- R6: A write miss is not answered until the number of acknowledgements equals the number of invalidates sent, however late the acknowledgements arrive.
- R7: After a write grant, the entry is exclusive with only the writer's bit set. An acknowledgement with `ack_dirty` = 1 writes `ack_data` into the block's memory word before the response.
- R8: A release (`req_op` = 2) clears the requester's presence bit. When the requester was the exclusive owner, `req_data` is written to memory; otherwise `req_data` is ignored. When no bit remains, the entry returns to uncached. The response carries the memory word after the release, with `rsp_excl` = 0.
- R9: `req_ready` is 0 from the cycle after a request is accepted until the cycle after its response. Exactly one response, addressed by `rsp_id` to the requester, is produced per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_op | input | 2 | 0 read miss, 1 write miss, 2 release |
| req_id | input | ID_W (2) | Requesting cache number |
| req_blk | input | BLK_W (4) | Block index |
| req_data | input | DATA_W (32) | Write-back data carried by a release |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_id | output | ID_W (2) | Cache the response is for |
| rsp_excl | output | 1 | Exclusive access granted |
| rsp_data | output | DATA_W (32) | Block data |
| msg_valid | output | 1 | Coherence message strobe |
| msg_kind | output | 1 | 0 invalidate, 1 fetch from owner |
| msg_dest | output | ID_W (2) | Target cache of the message |
| ack_valid | input | 1 | Acknowledgement of one earlier message |
| ack_dirty | input | 1 | Acknowledgement carries modified data |
| ack_data | input | DATA_W (32) | Data returned by the acknowledging cache |

## Verification
A single block is driven through a chain of misses in which the entry passes through every state. The chain includes reads that build up a sharer set of three, a write from one of those sharers, a read that meets an exclusive owner, and a write that steals from an owner with dirty data. Comparing the invalidate mask with the fetch mask shows whether targets come from the presence vector, with the requester left out. The returned data shows whether write-back data from acknowledgements and releases reached memory. Further cases cover a release by a plain sharer, the last release emptying the entry, acknowledgements held back for several cycles behind four sharers, and a reset in mid-sequence. Together they separate a correct ack count, correct ignoring of data, and a correct return to uncached from designs that merely produce a response.

// File: rtl/dirc_pkg.sv
package dirc_pkg;

    typedef enum logic [1:0] {
        DS_UNCACHED = 2'd0,
        DS_SHARED   = 2'd1,
        DS_EXCL     = 2'd2
    } dstate_e;

    typedef enum logic [1:0] {
        OP_READ    = 2'd0,
        OP_WRITE   = 2'd1,
        OP_RELEASE = 2'd2
    } op_e;

    typedef enum logic {
        MK_INV   = 1'b0,
        MK_FETCH = 1'b1
    } msgkind_e;

    typedef enum logic [1:0] {
        FS_IDLE   = 2'd0,
        FS_DECIDE = 2'd1,
        FS_WAIT   = 2'd2,
        FS_RESP   = 2'd3
    } fsm_e;

    localparam logic [31:0] MEM_SEED = 32'hA000_0000;

    // index of the lowest set bit of a mask (0 when empty)
    function automatic int unsigned low_index(input logic [31:0] m);
        int unsigned r;
        r = 0;
        for (int i = 31; i >= 0; i--) begin
            if (m[i]) r = i;
        end
        return r;
    endfunction

endpackage

// File: rtl/dirc_store.sv
module dirc_store
    import dirc_pkg::*;
#(
    parameter int N_CACHE = 4,
    parameter int N_BLK   = 16,
    parameter int DATA_W  = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic [$clog2(N_BLK)-1:0] rd_blk,
    output dstate_e                  rd_state,
    output logic [N_CACHE-1:0]       rd_pres,
    output logic [DATA_W-1:0]        rd_data,
    input  logic                     dir_we,
    input  dstate_e                  wr_state,
    input  logic [N_CACHE-1:0]       wr_pres,
    input  logic                     mem_we,
    input  logic [DATA_W-1:0]        mem_wdata
);
    localparam int BLK_W = $clog2(N_BLK);

    dstate_e            state_q [N_BLK];
    logic [N_CACHE-1:0] pres_q  [N_BLK];
    logic [DATA_W-1:0]  mem_q   [N_BLK];

    assign rd_state = state_q[rd_blk];
    assign rd_pres  = pres_q[rd_blk];
    assign rd_data  = mem_q[rd_blk];

    generate
        for (genvar b = 0; b < N_BLK; b++) begin : g_blk
            localparam logic [BLK_W-1:0] IDX = BLK_W'(b);
            always_ff @(posedge clk) begin
                if (rst) begin
                    state_q[b] <= DS_UNCACHED;
                    pres_q[b]  <= '0;
                    mem_q[b]   <= DATA_W'(MEM_SEED) + DATA_W'(b);
                end else begin
                    if (dir_we && rd_blk == IDX) begin
                        state_q[b] <= wr_state;
                        pres_q[b]  <= wr_pres;
                    end
                    if (mem_we && rd_blk == IDX) begin
                        mem_q[b] <= mem_wdata;
                    end
                end
            end
        end
    endgenerate

    // R7: an exclusive entry always names exactly one owner
    a_r7_excl_single: assert property (@(posedge clk) disable iff (rst)
        (dir_we && wr_state == DS_EXCL) |-> ($countones(wr_pres) == 1));

    // R8: uncached exactly when no presence bit remains
    a_r8_unc_empty: assert property (@(posedge clk) disable iff (rst)
        dir_we |-> ((wr_state == DS_UNCACHED) == (wr_pres == '0)));

endmodule

// File: rtl/dirc_fanout.sv
module dirc_fanout
    import dirc_pkg::*;
#(
    parameter int N_CACHE = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        load,
    input  logic [N_CACHE-1:0]          load_mask,
    input  msgkind_e                    load_kind,
    input  logic                        ack_valid,
    output logic                        msg_valid,
    output msgkind_e                    msg_kind,
    output logic [$clog2(N_CACHE)-1:0]  msg_dest,
    output logic                        done
);
    localparam int ID_W  = $clog2(N_CACHE);
    localparam int CNT_W = $clog2(N_CACHE + 1);

    logic [N_CACHE-1:0] remain_q;
    logic [CNT_W-1:0]   pend_q;
    msgkind_e           kind_q;

    assign msg_valid = |remain_q;
    assign msg_kind  = kind_q;
    assign msg_dest  = ID_W'(low_index(32'(remain_q)));
    assign done      = (remain_q == '0) && (pend_q == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
            pend_q   <= '0;
            kind_q   <= MK_INV;
        end else if (load) begin
            remain_q <= load_mask;
            pend_q   <= CNT_W'($countones(load_mask));
            kind_q   <= load_kind;
        end else begin
            if (msg_valid) remain_q[msg_dest] <= 1'b0;
            if (ack_valid && pend_q != '0) pend_q <= pend_q - 1'b1;
        end
    end

    // R6: an acknowledgement only arrives while one is outstanding
    a_r6_ack_expected: assert property (@(posedge clk) disable iff (rst)
        ack_valid |-> (pend_q != '0));

    // R4: one target is served per message cycle
    a_r4_one_per_cycle: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !load) |=>
            ($countones(remain_q) == $countones($past(remain_q)) - 1));

endmodule

// File: rtl/dir_home_ctrl.sv
module dir_home_ctrl
    import dirc_pkg::*;
#(
    parameter int N_CACHE = 4,
    parameter int N_BLK   = 16,
    parameter int DATA_W  = 32,
    localparam int ID_W   = $clog2(N_CACHE),
    localparam int BLK_W  = $clog2(N_BLK)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_op,
    input  logic [ID_W-1:0]   req_id,
    input  logic [BLK_W-1:0]  req_blk,
    input  logic [DATA_W-1:0] req_data,
    output logic              rsp_valid,
    output logic [ID_W-1:0]   rsp_id,
    output logic              rsp_excl,
    output logic [DATA_W-1:0] rsp_data,
    output logic              msg_valid,
    output logic              msg_kind,
    output logic [ID_W-1:0]   msg_dest,
    input  logic              ack_valid,
    input  logic              ack_dirty,
    input  logic [DATA_W-1:0] ack_data
);
    fsm_e              st_q;
    op_e               op_q;
    logic [ID_W-1:0]   id_q;
    logic [BLK_W-1:0]  blk_q;
    logic [DATA_W-1:0] data_q;

    dstate_e            rd_state;
    logic [N_CACHE-1:0] rd_pres;
    logic [DATA_W-1:0]  rd_data;
    logic               dir_we, mem_we;
    dstate_e            wr_state;
    logic [N_CACHE-1:0] wr_pres;
    logic [DATA_W-1:0]  mem_wdata;

    logic               fan_load, fan_done;
    logic [N_CACHE-1:0] fan_mask;
    msgkind_e           fan_kind, msg_kind_e;

    logic [N_CACHE-1:0] self_bit, others, left_after_rel;
    logic               rel_by_owner;

    assign self_bit       = N_CACHE'(1) << id_q;
    assign others         = rd_pres & ~self_bit;
    assign left_after_rel = rd_pres & ~self_bit;
    assign rel_by_owner   = (rd_state == DS_EXCL) && (rd_pres == self_bit);

    // targets of the coherence messages for the current request
    always_comb begin
        fan_kind = MK_INV;
        fan_mask = '0;
        unique case (op_q)
            OP_WRITE: begin
                fan_kind = MK_INV;
                fan_mask = others;
            end
            OP_RELEASE: fan_mask = '0;
            default: begin
                fan_kind = MK_FETCH;
                fan_mask = (rd_state == DS_EXCL) ? others : '0;
            end
        endcase
    end

    assign fan_load = (st_q == FS_DECIDE) && (fan_mask != '0);

    // entry and memory updates
    always_comb begin
        dir_we    = 1'b0;
        wr_state  = rd_state;
        wr_pres   = rd_pres;
        mem_we    = 1'b0;
        mem_wdata = ack_data;
        if (st_q == FS_WAIT && ack_valid && ack_dirty) begin
            mem_we = 1'b1;
        end
        if ((st_q == FS_DECIDE && fan_mask == '0) ||
            (st_q == FS_WAIT && fan_done)) begin
            dir_we = 1'b1;
            unique case (op_q)
                OP_WRITE: begin
                    wr_state = DS_EXCL;
                    wr_pres  = self_bit;
                end
                OP_RELEASE: begin
                    wr_pres  = left_after_rel;
                    wr_state = (left_after_rel == '0) ? DS_UNCACHED : rd_state;
                    if (rel_by_owner) begin
                        mem_we    = 1'b1;
                        mem_wdata = data_q;
                    end
                end
                default: begin
                    wr_state = DS_SHARED;
                    wr_pres  = rd_pres | self_bit;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= FS_IDLE;
            op_q   <= OP_READ;
            id_q   <= '0;
            blk_q  <= '0;
            data_q <= '0;
        end else begin
            unique case (st_q)
                FS_IDLE: if (req_valid) begin
                    st_q   <= FS_DECIDE;
                    op_q   <= op_e'(req_op);
                    id_q   <= req_id;
                    blk_q  <= req_blk;
                    data_q <= req_data;
                end
                FS_DECIDE: st_q <= (fan_mask == '0) ? FS_RESP : FS_WAIT;
                FS_WAIT:   if (fan_done) st_q <= FS_RESP;
                default:   st_q <= FS_IDLE;
            endcase
        end
    end

    dirc_store #(.N_CACHE(N_CACHE), .N_BLK(N_BLK), .DATA_W(DATA_W)) store_i (
        .clk       (clk),
        .rst       (rst),
        .rd_blk    (blk_q),
        .rd_state  (rd_state),
        .rd_pres   (rd_pres),
        .rd_data   (rd_data),
        .dir_we    (dir_we),
        .wr_state  (wr_state),
        .wr_pres   (wr_pres),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata)
    );

    dirc_fanout #(.N_CACHE(N_CACHE)) fan_i (
        .clk       (clk),
        .rst       (rst),
        .load      (fan_load),
        .load_mask (fan_mask),
        .load_kind (fan_kind),
        .ack_valid (ack_valid),
        .msg_valid (msg_valid),
        .msg_kind  (msg_kind_e),
        .msg_dest  (msg_dest),
        .done      (fan_done)
    );

    assign msg_kind  = msg_kind_e;
    assign req_ready = (st_q == FS_IDLE);
    assign rsp_valid = (st_q == FS_RESP);
    assign rsp_id    = id_q;
    assign rsp_excl  = (st_q == FS_RESP) && (op_q == OP_WRITE);
    assign rsp_data  = rd_data;

    // R5: the requester is never a message target
    a_r5_no_self_target: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> (msg_dest != id_q));

    // R6: no response while messages or acks are outstanding
    a_r6_grant_after_acks: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> fan_done);

    // R9: busy while a response is out
    a_r9_busy_hold: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> !req_ready);

    // R9: response and messages never overlap
    a_r9_no_overlap: assert property (@(posedge clk) disable iff (rst)
        !(msg_valid && rsp_valid));

endmodule

// File: tb/dir_home_ctrl_tb.sv
module dir_home_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [1:0]  op;
        logic [1:0]  id;
        logic [3:0]  blk;
        logic [31:0] wdata;
        logic [31:0] odata;
        logic [3:0]  inv;
        logic [3:0]  fetch;
        logic [31:0] data;
        logic        excl;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 2'd0, 4'd3, 32'h0,        32'h0,        4'h0, 4'h0, 32'hA000_0003, 1'b0},
        '{2'd0, 2'd1, 4'd3, 32'h0,        32'h0,        4'h0, 4'h0, 32'hA000_0003, 1'b0},
        '{2'd0, 2'd2, 4'd3, 32'h0,        32'h0,        4'h0, 4'h0, 32'hA000_0003, 1'b0},
        '{2'd1, 2'd1, 4'd3, 32'h0,        32'h0,        4'h5, 4'h0, 32'hA000_0003, 1'b1},
        '{2'd0, 2'd3, 4'd3, 32'h0,        32'h1111_1111, 4'h0, 4'h2, 32'h1111_1111, 1'b0},
        '{2'd1, 2'd0, 4'd3, 32'h0,        32'h0,        4'hA, 4'h0, 32'h1111_1111, 1'b1},
        '{2'd1, 2'd2, 4'd3, 32'h0,        32'h2222_2222, 4'h1, 4'h0, 32'h2222_2222, 1'b1},
        '{2'd1, 2'd2, 4'd3, 32'h0,        32'h0,        4'h0, 4'h0, 32'h2222_2222, 1'b1},
        '{2'd2, 2'd2, 4'd3, 32'h3333_3333, 32'h0,       4'h0, 4'h0, 32'h3333_3333, 1'b0},
        '{2'd0, 2'd1, 4'd3, 32'h0,        32'h0,        4'h0, 4'h0, 32'h3333_3333, 1'b0},
        '{2'd1, 2'd1, 4'd5, 32'h0,        32'h0,        4'h0, 4'h0, 32'hA000_0005, 1'b1},
        '{2'd0, 2'd0, 4'd3, 32'h0,        32'h0,        4'h0, 4'h0, 32'h3333_3333, 1'b0},
        '{2'd2, 2'd0, 4'd3, 32'h4444_4444, 32'h0,       4'h0, 4'h0, 32'h3333_3333, 1'b0},
        '{2'd2, 2'd1, 4'd3, 32'h5555_5555, 32'h0,       4'h0, 4'h0, 32'h3333_3333, 1'b0},
        '{2'd1, 2'd3, 4'd3, 32'h0,        32'h0,        4'h0, 4'h0, 32'h3333_3333, 1'b1},
        '{2'd0, 2'd0, 4'd5, 32'h0,        32'h5555_5555, 4'h0, 4'h2, 32'h5555_5555, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_ready;
    logic [1:0]  req_op;
    logic [1:0]  req_id;
    logic [3:0]  req_blk;
    logic [31:0] req_data;
    logic        rsp_valid;
    logic [1:0]  rsp_id;
    logic        rsp_excl;
    logic [31:0] rsp_data;
    logic        msg_valid;
    logic        msg_kind;
    logic [1:0]  msg_dest;
    logic        ack_valid;
    logic        ack_dirty;
    logic [31:0] ack_data;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;
    always @(posedge clk) cycles <= cycles + 1;

    dir_home_ctrl dut_i (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_op    (req_op),
        .req_id    (req_id),
        .req_blk   (req_blk),
        .req_data  (req_data),
        .rsp_valid (rsp_valid),
        .rsp_id    (rsp_id),
        .rsp_excl  (rsp_excl),
        .rsp_data  (rsp_data),
        .msg_valid (msg_valid),
        .msg_kind  (msg_kind),
        .msg_dest  (msg_dest),
        .ack_valid (ack_valid),
        .ack_dirty (ack_dirty),
        .ack_data  (ack_data)
    );

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic apply_reset();
        @(negedge clk);
        rst = 1'b1;
        req_valid = 1'b0;
        ack_valid = 1'b0;
        ack_dirty = 1'b0;
        ack_data  = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
    endtask

    // one request; responds to messages as the caches would
    task automatic txn(input logic [1:0] op, input logic [1:0] id,
                       input logic [3:0] blk, input logic [31:0] wdata,
                       input logic [31:0] odata, input int lag,
                       output logic [3:0] inv_m, output logic [3:0] fetch_m,
                       output logic [31:0] data, output logic excl,
                       output logic [1:0] rid, output logic early,
                       output logic busy_ok, output logic got);
        logic [3:0] pend;
        int since;
        inv_m = '0; fetch_m = '0; data = '0; excl = 1'b0; rid = '0;
        early = 1'b0; busy_ok = 1'b1; got = 1'b0;
        pend = '0; since = 0;
        req_valid = 1'b1; req_op = op; req_id = id; req_blk = blk; req_data = wdata;
        @(negedge clk);
        req_valid = 1'b0;
        for (int t = 0; t < 60 && !got; t++) begin
            ack_valid = 1'b0;
            ack_dirty = 1'b0;
            if (req_ready) busy_ok = 1'b0;
            if (rsp_valid) begin
                got = 1'b1;
                if (pend != '0) early = 1'b1;
                data = rsp_data; excl = rsp_excl; rid = rsp_id;
            end else begin
                if (msg_valid) begin
                    if (msg_kind) fetch_m[msg_dest] = 1'b1;
                    else          inv_m[msg_dest]   = 1'b1;
                    pend[msg_dest] = 1'b1;
                    since = 0;
                end else begin
                    since++;
                    if (pend != '0 && since > lag) begin
                        for (int k = 3; k >= 0; k--) begin
                            if (pend[k]) begin
                                ack_valid = 1'b1;
                                ack_dirty = (odata != '0);
                                ack_data  = odata;
                            end
                        end
                        for (int k = 0; k < 4; k++) begin
                            if (pend[k]) begin
                                pend[k] = 1'b0;
                                break;
                            end
                        end
                    end
                end
                @(negedge clk);
            end
        end
        ack_valid = 1'b0;
        ack_dirty = 1'b0;
        @(negedge clk);
        // R9: ready returns one cycle after the response
        check("R9", "ready after response", 32'(req_ready), 32'd1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [3:0]  inv_m, fetch_m;
        logic [31:0] data;
        logic        excl, early, busy_ok, got;
        logic [1:0]  rid;
        string       tag;

        rst = 1'b1;
        req_valid = 1'b0; req_op = '0; req_id = '0; req_blk = '0; req_data = '0;
        ack_valid = 1'b0; ack_dirty = 1'b0; ack_data = '0;
        apply_reset();

        // R1: outputs after reset
        check("R1", "req_ready", 32'(req_ready), 32'd1);
        check("R1", "rsp_valid", 32'(rsp_valid), 32'd0);
        check("R1", "msg_valid", 32'(msg_valid), 32'd0);

        // vector walk
        for (int v = 0; v < NV; v++) begin
            vec_t e;
            e = VECS[v];
            if (e.op == 2'd2)        tag = "R8";
            else if (e.fetch != '0)  tag = "R3";
            else if (e.inv != '0)    tag = "R4";
            else if (e.op == 2'd1)   tag = "R7";
            else                     tag = "R2";
            txn(e.op, e.id, e.blk, e.wdata, e.odata, 0,
                inv_m, fetch_m, data, excl, rid, early, busy_ok, got);
            check(tag, $sformatf("vec%0d response seen", v), 32'(got), 32'd1);
            check("R5", $sformatf("vec%0d invalidate mask", v), 32'(inv_m), 32'(e.inv));
            check(tag, $sformatf("vec%0d fetch mask", v), 32'(fetch_m), 32'(e.fetch));
            check(tag, $sformatf("vec%0d data", v), data, e.data);
            check(tag, $sformatf("vec%0d excl", v), 32'(excl), 32'(e.excl));
            check("R9", $sformatf("vec%0d rsp_id", v), 32'(rid), 32'(e.id));
            check("R9", $sformatf("vec%0d busy", v), 32'(busy_ok), 32'd1);
        end

        // R6: four sharers, acks held back several cycles each
        for (int c = 0; c < 4; c++) begin
            txn(2'd0, 2'(c), 4'd9, '0, '0, 0,
                inv_m, fetch_m, data, excl, rid, early, busy_ok, got);
        end
        txn(2'd1, 2'd0, 4'd9, '0, '0, 6,
            inv_m, fetch_m, data, excl, rid, early, busy_ok, got);
        check("R6", "late acks invalidate mask", 32'(inv_m), 32'hE);
        check("R6", "no early grant", 32'(early), 32'd0);
        check("R6", "grant data", data, 32'hA000_0009);
        check("R7", "grant excl", 32'(excl), 32'd1);

        // R8: release of an untracked block changes nothing
        txn(2'd2, 2'd1, 4'd4, 32'hDEAD_BEEF, '0, 0,
            inv_m, fetch_m, data, excl, rid, early, busy_ok, got);
        check("R8", "stray release data", data, 32'hA000_0004);
        txn(2'd1, 2'd2, 4'd4, '0, '0, 0,
            inv_m, fetch_m, data, excl, rid, early, busy_ok, got);
        check("R8", "block still uncached", 32'(inv_m), 32'd0);

        // R1: reset in mid-sequence restores memory and directory
        apply_reset();
        check("R1", "ready after second reset", 32'(req_ready), 32'd1);
        txn(2'd1, 2'd0, 4'd3, '0, '0, 0,
            inv_m, fetch_m, data, excl, rid, early, busy_ok, got);
        check("R1", "no sharers after reset", 32'(inv_m | fetch_m), 32'd0);
        check("R1", "memory seed after reset", data, 32'hA000_0003);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule